// File: doc/BRIEF.md
# Frame-Synchronized Stream Control Gate

This stage sits in a packetized video stream and pairs it with a small memory-mapped control slave. The stream uses valid/ready handshaking with start-of-packet and end-of-packet markers. On the first beat of every packet, the low four bits of the data word carry the packet type. Type 0 marks an image packet; any other type is auxiliary traffic.

Auxiliary packets always flow straight through. When an image packet header reaches the head of the two-entry input skid buffer, the stage holds it there until software has set the run bit. Once the run bit is seen, the stage copies the user control registers into shadow copies and raises the busy flag in the same cycle. The header and the rest of the frame then go out unchanged, with the shadow values presented on a side output for the downstream pixel logic. Software can therefore rewrite the control registers at any time and know that a frame never sees a half-updated set of values. Clearing the run bit makes the stage stop at the next image header, not in the middle of a frame.

Top module: `frame_gate`

## Requirements
- R1: Offset 0 holds the run bit in bit 0, and it reads back what was written. Without any write, it reads 0 once CLR_DELAY (default 3) cycles have passed after reset release.
- R2: Offset 1 is the busy flag in bit 0, and bits above 0 always read 0. Writes to offset 1 change nothing that can be read.
- R3: A read strobe returns data on csr_rdata one clock later. Offsets 2 and 3 hold the user control registers and read back what was written. Offsets 4 to 7 read as zero.
- R4: A packet whose first-beat type (data bits [3:0]) is nonzero is forwarded beat for beat with identical data, sop and eop, whatever the run bit holds. A stalled output beat stays valid and unchanged.
- R5: While the run bit is 0, a type-0 header is not forwarded and the busy flag reads 0. No image beat leaves while busy is 0.
- R6: The run bit is sampled at a clock edge while the stage waits at a type-0 header. If it is 1, then in the following cycle out_ctrl equals the user registers, the busy flag is 1, and the header is offered on the output.
- R7: Clearing the run bit during a frame lets that frame finish completely, and the next type-0 header stalls.
- R8: Writes to the user registers during a frame leave out_ctrl unchanged until the next frame start. At that frame start, the new values are loaded.
- R9: While the output is stalled at an image header, the input accepts exactly two beats (the header and one more), then deasserts in_ready.
- R10: The busy flag reads 0 again after the last beat of an image packet has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Register offset |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_wdata | input | REG_W | Write data |
| csr_rdata | output | REG_W | Read data, one cycle after csr_rd |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input beat data, type in [TYPE_W-1:0] on first beat |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | DATA_W | Output beat data |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_ctrl | output | N_USER*REG_W | Shadow copies of user registers |

## Verification
The main function is driven with a mix of packets:
- Auxiliary packets sent with the run bit clear show that gating depends on the type field and not on the run bit.
- Image packets sent with the run bit already set show that the load is immediate.
- Image packets sent with the run bit clear expose the stall, the skid occupancy and the exact cycle of release.
- Single-beat packets, where sop and eop fall on the same beat, separate the header handling from the end-of-frame handling.

A long frame, during which the run bit is cleared and a user register is rewritten, distinguishes a correct frame-boundary gate from one that reacts mid-frame. Every output beat is compared in order against the log of accepted input beats.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_AUX   = 2'd1,
      ST_HOLD  = 2'd2,
      ST_FRAME = 2'd3
   } fg_state_e;

   localparam int OFS_RUN  = 0;
   localparam int OFS_BUSY = 1;
   localparam int OFS_USER = 2;
endpackage

// File: rtl/fg_skid.sv
module fg_skid #(
   parameter int W     = 26,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_word,
   output logic         head_valid,
   input  logic         head_ready,
   output logic [W-1:0] head_word
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fg_skid: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          push, pop;

   assign in_ready   = (cnt != CW'(DEPTH));
   assign head_valid = (cnt != '0);
   assign head_word  = mem[rp];
   assign push       = in_valid & in_ready;
   assign pop        = head_valid & head_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_word;
   end
endmodule

// File: rtl/fg_csr.sv
module fg_csr
   import fg_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int REG_W     = 16,
   parameter int N_USER    = 2,
   parameter int CLR_DELAY = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         csr_addr,
   input  logic                      csr_wr,
   input  logic                      csr_rd,
   input  logic [REG_W-1:0]          csr_wdata,
   output logic [REG_W-1:0]          csr_rdata,
   input  logic                      busy,
   output logic                      run,
   output logic                      init_done,
   output logic [N_USER*REG_W-1:0]   user_flat
);
   localparam int CW = $clog2(CLR_DELAY + 1);

   logic [CW-1:0]    init_cnt;
   logic             clr_pulse;
   logic [REG_W-1:0] rd_mux;

   assign clr_pulse = !init_done && (init_cnt == CW'(CLR_DELAY - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_cnt  <= '0;
         init_done <= 1'b0;
      end else if (!init_done) begin
         if (clr_pulse) init_done <= 1'b1;
         else           init_cnt  <= init_cnt + 1'b1;
      end
   end

   // run bit has no reset value: it is forced low once the init count expires
   always_ff @(posedge clk) begin
      if (clr_pulse)
         run <= 1'b0;
      else if (csr_wr && csr_addr == ADDR_W'(OFS_RUN))
         run <= csr_wdata[0];
   end

   genvar g;
   generate
      for (g = 0; g < N_USER; g++) begin : g_user
         logic [REG_W-1:0] ureg;
         always_ff @(posedge clk) begin
            if (csr_wr && csr_addr == ADDR_W'(OFS_USER + g))
               ureg <= csr_wdata;
         end
         assign user_flat[g*REG_W +: REG_W] = ureg;
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (csr_addr == ADDR_W'(OFS_RUN))  rd_mux[0] = run;
      if (csr_addr == ADDR_W'(OFS_BUSY)) rd_mux[0] = busy;
      for (int i = 0; i < N_USER; i++) begin
         if (csr_addr == ADDR_W'(OFS_USER + i))
            rd_mux = user_flat[i*REG_W +: REG_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      csr_rdata <= '0;
      else if (csr_rd) csr_rdata <= rd_mux;
   end
endmodule

// File: rtl/fg_seq.sv
module fg_seq
   import fg_pkg::*;
#(
   parameter int TYPE_W = 4,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic              head_sop,
   input  logic              head_eop,
   input  logic [TYPE_W-1:0] head_type,
   input  logic              out_ready,
   input  logic              run_ok,
   input  logic [CTRL_W-1:0] user_flat,
   output logic              fwd,
   output logic              busy,
   output logic [CTRL_W-1:0] shadow
);
   fg_state_e state, state_nx;
   logic      img_hdr, pop, load;

   assign img_hdr = head_valid & head_sop & (head_type == '0);
   assign pop     = head_valid & fwd & out_ready;

   always_comb begin
      state_nx = state;
      fwd      = 1'b0;
      load     = 1'b0;
      case (state)
         ST_IDLE: begin
            if (img_hdr) begin
               state_nx = ST_HOLD;
            end else begin
               fwd = 1'b1;
               if (pop && head_sop && !head_eop) state_nx = ST_AUX;
            end
         end
         ST_AUX: begin
            fwd = 1'b1;
            if (pop && head_eop) state_nx = ST_IDLE;
         end
         ST_HOLD: begin
            if (run_ok) begin
               load     = 1'b1;
               state_nx = ST_FRAME;
            end
         end
         default: begin
            fwd = 1'b1;
            if (pop && head_eop) state_nx = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         busy   <= 1'b0;
         shadow <= '0;
      end else begin
         state <= state_nx;
         if (load) begin
            busy   <= 1'b1;
            shadow <= user_flat;
         end else if (state == ST_FRAME && pop && head_eop) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/frame_gate.sv
module frame_gate
   import fg_pkg::*;
#(
   parameter int DATA_W     = 24,
   parameter int TYPE_W     = 4,
   parameter int REG_W      = 16,
   parameter int N_USER     = 2,
   parameter int ADDR_W     = 3,
   parameter int CLR_DELAY  = 3,
   parameter int SKID_DEPTH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       csr_addr,
   input  logic                    csr_wr,
   input  logic                    csr_rd,
   input  logic [REG_W-1:0]        csr_wdata,
   output logic [REG_W-1:0]        csr_rdata,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [DATA_W-1:0]       in_data,
   input  logic                    in_sop,
   input  logic                    in_eop,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_sop,
   output logic                    out_eop,
   output logic [N_USER*REG_W-1:0] out_ctrl
);
   localparam int WORD_W = DATA_W + 2;
   localparam int CTRL_W = N_USER * REG_W;

   generate
      if (TYPE_W < 1 || TYPE_W > DATA_W) begin : g_bad_type
         $error("frame_gate: TYPE_W must lie in 1..DATA_W");
      end
      if (REG_W < 2) begin : g_bad_reg
         $error("frame_gate: REG_W must be at least 2");
      end
      if (N_USER < 1 || OFS_USER + N_USER > (1 << ADDR_W)) begin : g_bad_map
         $error("frame_gate: user registers do not fit the address space");
      end
      if (CLR_DELAY < 1) begin : g_bad_delay
         $error("frame_gate: CLR_DELAY must be at least 1");
      end
   endgenerate

   logic              head_valid, head_ready, fwd;
   logic [WORD_W-1:0] head_word;
   logic              run_w, busy_w, init_w;
   logic [CTRL_W-1:0] user_w;

   fg_skid #(.W(WORD_W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_word    ({in_sop, in_eop, in_data}),
      .head_valid (head_valid),
      .head_ready (head_ready),
      .head_word  (head_word)
   );

   fg_csr #(.ADDR_W(ADDR_W), .REG_W(REG_W), .N_USER(N_USER),
            .CLR_DELAY(CLR_DELAY)) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_addr  (csr_addr),
      .csr_wr    (csr_wr),
      .csr_rd    (csr_rd),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .busy      (busy_w),
      .run       (run_w),
      .init_done (init_w),
      .user_flat (user_w)
   );

   fg_seq #(.TYPE_W(TYPE_W), .CTRL_W(CTRL_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (head_valid),
      .head_sop   (head_word[WORD_W-1]),
      .head_eop   (head_word[WORD_W-2]),
      .head_type  (head_word[TYPE_W-1:0]),
      .out_ready  (out_ready),
      .run_ok     (run_w & init_w),
      .user_flat  (user_w),
      .fwd        (fwd),
      .busy       (busy_w),
      .shadow     (out_ctrl)
   );

   assign out_valid  = head_valid & fwd;
   assign head_ready = fwd & out_ready;
   assign out_data   = head_word[DATA_W-1:0];
   assign out_sop    = head_word[WORD_W-1];
   assign out_eop    = head_word[WORD_W-2];
endmodule

// File: rtl/fg_check.sv
module fg_check #(
   parameter int DATA_W = 24,
   parameter int TYPE_W = 4,
   parameter int REG_W  = 16,
   parameter int N_USER = 2,
   parameter int ADDR_W = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       csr_addr,
   input logic                    csr_rd,
   input logic [REG_W-1:0]        csr_rdata,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [DATA_W-1:0]       out_data,
   input logic                    out_sop,
   input logic [N_USER*REG_W-1:0] out_ctrl,
   input logic                    busy,
   input logic                    run,
   input logic                    init_done
);
   assert_run_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> !run);

   assert_busy_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr == ADDR_W'(1)) |=> (csr_rdata[REG_W-1:1] == '0));

   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && (int'(csr_addr) >= 2 + N_USER)) |=> (csr_rdata == '0));

   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_no_image_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop && out_data[TYPE_W-1:0] == '0) |-> busy);

   assert_shadow_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(out_ctrl));
endmodule

bind frame_gate fg_check #(
   .DATA_W(DATA_W), .TYPE_W(TYPE_W), .REG_W(REG_W),
   .N_USER(N_USER), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .csr_addr  (csr_addr),
   .csr_rd    (csr_rd),
   .csr_rdata (csr_rdata),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_sop   (out_sop),
   .out_ctrl  (out_ctrl),
   .busy      (busy_w),
   .run       (run_w),
   .init_done (init_w)
);

// File: tb/sim_frame_gate.sv
`timescale 1ns/1ps
module sim_frame_gate;
   localparam int DATA_W = 24;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 3;
   localparam int N_USER = 2;
   localparam int NV     = 7;
   // vector: [15:12] type, [11:4] beats, [0] run bit before sending
   localparam logic [15:0] VEC [NV] = '{
      16'h3040, 16'h0051, 16'h7021, 16'h0030, 16'hF010, 16'h0011, 16'h0040
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] csr_addr = '0;
   logic csr_wr = 1'b0, csr_rd = 1'b0;
   logic [REG_W-1:0] csr_wdata = '0;
   logic [REG_W-1:0] csr_rdata;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic in_ready, out_valid, out_sop, out_eop;
   logic out_ready = 1'b1;
   logic [DATA_W-1:0] out_data;
   logic [N_USER*REG_W-1:0] out_ctrl;

   always #2 clk = ~clk;

   frame_gate u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
      .csr_rd(csr_rd), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .out_ctrl(out_ctrl)
   );

   int n_chk = 0, n_bad = 0;
   int acc_cnt = 0, out_cnt = 0, pkt_id = 0;
   logic [DATA_W+1:0] sent_log [$];

   task automatic chk(input bit ok, input string req, input longint got, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic csr_write(input int a, input logic [REG_W-1:0] d);
      @(posedge clk); #1;
      csr_addr = ADDR_W'(a); csr_wdata = d; csr_wr = 1'b1;
      @(posedge clk); #1;
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input int a, output logic [REG_W-1:0] d);
      @(posedge clk); #1;
      csr_addr = ADDR_W'(a); csr_rd = 1'b1;
      @(posedge clk); #1;
      csr_rd = 1'b0;
      d = csr_rdata;
   endtask

   task automatic send_pkt(input logic [3:0] ptype, input int beats);
      int id = pkt_id++;
      @(posedge clk); #1;
      for (int b = 0; b < beats; b++) begin
         in_valid = 1'b1;
         in_sop   = (b == 0);
         in_eop   = (b == beats - 1);
         in_data  = {id[11:0], b[7:0], (b == 0) ? ptype : 4'h5};
         forever begin
            @(negedge clk);
            if (in_ready) break;
         end
         @(posedge clk);
         sent_log.push_back({in_sop, in_eop, in_data});
         acc_cnt++;
         #1;
      end
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   // output monitor: every beat matches the accepted input log in order (R4)
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         logic [DATA_W+1:0] exp_w;
         exp_w = (sent_log.size() != 0) ? sent_log.pop_front() : '1;
         out_cnt++;
         chk({out_sop, out_eop, out_data} == exp_w, "R4 beat order/content",
             longint'({out_sop, out_eop, out_data}), longint'(exp_w));
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] uval;
      int target, base;

      // reset state
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 reset out_valid", out_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      csr_read(0, rd);  chk(rd == 16'h0, "R1 run cleared after reset", rd, 0);
      csr_read(1, rd);  chk(rd == 16'h0, "R2 busy low after reset", rd, 0);
      csr_write(1, 16'hFFFF);
      csr_read(1, rd);  chk(rd == 16'h0, "R2 write to busy ignored", rd, 0);
      csr_write(2, 16'hBEEF); csr_write(3, 16'h1234);
      csr_read(2, rd);  chk(rd == 16'hBEEF, "R3 user0 readback", rd, 16'hBEEF);
      csr_read(3, rd);  chk(rd == 16'h1234, "R3 user1 readback", rd, 16'h1234);
      csr_read(4, rd);  chk(rd == 16'h0, "R3 unmapped 4", rd, 0);
      csr_read(7, rd);  chk(rd == 16'h0, "R3 unmapped 7", rd, 0);
      csr_write(0, 16'hFFFF);
      csr_read(0, rd);  chk(rd == 16'h1, "R1 run readback", rd, 1);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [3:0] ptype = VEC[v][15:12];
         int beats = int'(VEC[v][11:4]);
         bit runv = VEC[v][0];
         uval = 16'hA000 + REG_W'(v);
         csr_write(2, uval);
         csr_write(0, {15'd0, runv});
         base = out_cnt;
         target = out_cnt + beats;
         fork send_pkt(ptype, beats); join_none
         if (ptype == 4'h0 && !runv) begin
            repeat (10) @(negedge clk);
            chk(out_cnt == base, "R5 header held while run low", out_cnt, base);
            chk(acc_cnt - base == ((beats < 2) ? beats : 2), "R9 skid accepts two",
                acc_cnt - base, (beats < 2) ? beats : 2);
            if (beats > 2) chk(in_ready == 1'b0, "R9 in_ready low when full", in_ready, 0);
            csr_read(1, rd); chk(rd == 16'h0, "R5 busy low while held", rd, 0);
            csr_write(0, 16'h1);
            @(negedge clk);
            chk(out_valid == 1'b0, "R6 no release before sample", out_valid, 0);
            @(negedge clk);
            chk(out_valid && out_sop, "R6 header offered", {out_valid, out_sop}, 3);
            chk(out_ctrl[15:0] == uval, "R6 shadow loaded", out_ctrl[15:0], uval);
            wait (out_cnt == target);
         end else begin
            wait (out_cnt == target);
            if (ptype == 4'h0)
               chk(out_ctrl[15:0] == uval, "R6 shadow at frame start", out_ctrl[15:0], uval);
            else
               chk(1'b1, "R4 aux packet passed", out_cnt, target);
         end
         csr_read(1, rd); chk(rd == 16'h0, "R10 busy low after packet", rd, 0);
      end

      // long frame: run cleared and user reg rewritten mid-frame
      csr_write(2, 16'h1111); csr_write(3, 16'h3333); csr_write(0, 16'h1);
      target = out_cnt + 20;
      fork send_pkt(4'h0, 20); join_none
      repeat (6) @(posedge clk);
      csr_write(2, 16'h2222);
      csr_write(0, 16'h0);
      @(negedge clk);
      chk(out_ctrl[15:0] == 16'h1111, "R8 shadow frozen mid-frame", out_ctrl[15:0], 16'h1111);
      chk(out_ctrl[31:16] == 16'h3333, "R6 user1 shadowed", out_ctrl[31:16], 16'h3333);
      csr_read(1, rd); chk(rd == 16'h1, "R2 busy reads 1 in frame", rd, 1);
      wait (out_cnt == target);
      chk(out_cnt == target, "R7 frame completes after run cleared", out_cnt, target);
      csr_read(1, rd); chk(rd == 16'h0, "R10 busy low after frame", rd, 0);
      base = out_cnt;
      target = out_cnt + 3;
      fork send_pkt(4'h0, 3); join_none
      repeat (10) @(negedge clk);
      chk(out_cnt == base, "R7 next header stalls", out_cnt, base);
      csr_write(0, 16'h1);
      wait (out_cnt == target);
      chk(out_ctrl[15:0] == 16'h2222, "R8 new value at next frame", out_ctrl[15:0], 16'h2222);

      // single-beat aux packet with run low and downstream back-pressure
      csr_write(0, 16'h0);
      out_ready = 1'b0;
      target = out_cnt + 1;
      fork send_pkt(4'h9, 1); join_none
      repeat (4) @(negedge clk);
      chk(out_valid && out_sop && out_eop, "R4 aux offered with run low",
          {out_valid, out_sop, out_eop}, 7);
      out_ready = 1'b1;
      wait (out_cnt == target);
      repeat (3) @(posedge clk);
      chk(sent_log.size() == 0, "R4 all beats delivered", sent_log.size(), 0);

      summary();
      $finish;
   end
endmodule